// File: doc/BRIEF.md
# Bounded-Wait I2C Byte Master

This block is a single-master I2C controller driven one command at a time by a sequencer. Each command is a single bus step: open the bus with a START condition (or a repeated START when the bus is already held), send an address byte, send a data byte, receive a data byte with a chosen acknowledge, or close the bus with a STOP condition. Longer operations, such as a register read from a slave, are built by issuing these steps in sequence. A register read is the device address with the write bit, then the register index, then a repeated START, then the device address with the read bit, then the data bytes.

SCL and SDA are open-drain. The block only pulls each line low or releases it, and it reads the real bus level back through a synchronizer. A slave that holds SCL low to stretch the clock is waited for. No wait is open-ended, though. Every accepted command runs under a down-counter that is reloaded when the command starts. If the counter runs out, the master releases both lines, marks the bus closed, returns to idle and raises a sticky error flag.

A STOP request while no transaction is open is refused without touching any state. Byte commands issued while the bus is closed are refused in the same way. In both cases the bus and the controller are left exactly as they were, so that the next START and the acknowledge checks that follow it work normally.

Top module: `i2c_bounded_master`

## Requirements
- R1: SCL is driven with a period of 4*QDIV controller clocks (2*QDIV low, 2*QDIV high) when no slave stretches it. A byte command (cmd_op 2, 3 or 4) produces exactly 9 SCL rising edges and completes (done) 36*QDIV+1 clocks after the command is driven.
- R2: An address command (cmd_op=3) sends the wire byte {cmd_data[6:0], cmd_flag}, MSB first. A 7-bit address 0x08 therefore appears as 0x10 with cmd_flag=0 (write) and as 0x11 with cmd_flag=1 (read).
- R3: A START (cmd_op=1) issued while the bus is closed makes SDA fall while SCL is high, and sets bus_open once it completes. A START issued while the bus is open produces a repeated START and bus_open stays 1. While the block is idle with the bus closed, it pulls neither line.
- R4: A STOP (cmd_op=5) issued while bus_open=0 is refused: rejected pulses for one cycle, busy stays 0, neither line is pulled, and a full transaction issued afterwards succeeds.
- R5: A STOP issued while the bus is open releases SDA while SCL is high. done is raised only after SDA has been observed high with SCL high, and bus_open then reads 0.
- R6: No accepted command stays busy for more than TIMEOUT+1 cycles. On expiry the master releases SCL and SDA, clears bus_open and busy, and sets timeout_err. The error is visible TIMEOUT+2 clocks after the command is driven.
- R7: timeout_err stays set until the next command that is carried out. A rejected command leaves it set, and an accepted command clears it.
- R8: A slave holding SCL low for fewer cycles than the remaining timeout budget stretches the transfer and causes no error. The byte is still delivered correctly.
- R9: A read command (cmd_op=4) answers the 9th clock with ACK (SDA low) when cmd_flag=0 and with NACK (SDA released) when cmd_flag=1. rx_byte holds the 8 received bits, MSB first, once done is raised.
- R10: The sequence START, address(w), register index, repeated START, address(r), reads returns the slave register contents starting at that index.
- R11: After an address or write command, ack_nack holds the SDA level sampled on the 9th clock: 0 for ACK, 1 for NACK.
- R12: A byte command (cmd_op 2, 3 or 4) issued while bus_open=0 is refused with a one-cycle rejected pulse and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe; taken only when busy is 0 |
| cmd_op | input | 3 | 1 START, 2 write byte, 3 address byte, 4 read byte, 5 STOP |
| cmd_data | input | 8 | Write data, or the 7-bit address in bits 6:0 |
| cmd_flag | input | 1 | Read/write bit for an address command; NACK select for a read command |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command completes |
| rejected | output | 1 | One-cycle pulse when a command is refused |
| timeout_err | output | 1 | Sticky wait-expiry flag |
| bus_open | output | 1 | A transaction begun by START has not yet been closed |
| rx_byte | output | 8 | Last received data byte |
| ack_nack | output | 1 | Acknowledge bit seen after the last transmitted byte (1 = NACK) |
| scl_in | input | 1 | Level of the SCL line |
| sda_in | input | 1 | Level of the SDA line |
| scl_pull | output | 1 | Pull SCL low when 1; release when 0 |
| sda_pull | output | 1 | Pull SDA low when 1; release when 0 |

## Verification
A corrupted internal state shows up at the ports in a few typical ways. A refused STOP that disturbs the controller leaves bus_open set or a line pulled in the cycle after rejected. A sequencer that never gets done means a wait with no bound, and the block must instead report timeout_err exactly TIMEOUT+2 clocks after the command. A bit counter off by one shows up in the byte delivered to the slave, in the count of SCL edges per byte, and in a done pulse that arrives at any cycle other than 36*QDIV+1. A wrong acknowledge decision appears on the 9th clock as seen by the slave model. The bench follows the idle-release rule on every clock and, for the other behaviours, compares the exact cycle and the delivered data against its own model.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_WRITE = 3'd2,
    OP_ADDR  = 3'd3,
    OP_READ  = 3'd4,
    OP_STOP  = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ST_A, S_ST_B, S_ST_C, S_ST_D,
    S_B_L0, S_B_L1, S_B_H0, S_B_H1,
    S_SP_A, S_SP_B, S_SP_C, S_SP_D
  } state_e;
endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], d[g]};
    end
    assign q[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int QDIV = 78
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/i2cb_watch.sv
module i2cb_watch #(
  parameter int LIMIT = 6000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] START_VAL = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= START_VAL;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);
endmodule

// File: rtl/i2c_bounded_master.sv
module i2c_bounded_master
  import i2cb_pkg::*;
#(
  parameter int QDIV        = 78,
  parameter int TIMEOUT     = 6000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [BYTE_W-1:0]   cmd_data,
  input  logic                cmd_flag,
  output logic                busy,
  output logic                done,
  output logic                rejected,
  output logic                timeout_err,
  output logic                bus_open,
  output logic [BYTE_W-1:0]   rx_byte,
  output logic                ack_nack,
  input  logic                scl_in,
  input  logic                sda_in,
  output logic                scl_pull,
  output logic                sda_pull
);
  localparam int BW = $clog2(BYTE_W + 1);
  localparam logic [BW-1:0] ACK_BIT = BW'(BYTE_W);

  state_e            state;
  logic              open_q, busy_q, done_q, rej_q, err_q;
  logic              scl_low_q, sda_low_q;
  logic [BYTE_W-1:0] shreg, rx_q;
  logic [BW-1:0]     bitn;
  logic              rd_mode, nack_last, ackn_q;
  logic              tick, expired, accept, scl_s, sda_s;
  logic [1:0]        line_s;

  assign accept = cmd_valid && !busy_q;

  i2cb_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2cb_tick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst(rst), .clr(accept), .tick(tick)
  );

  i2cb_watch #(.LIMIT(TIMEOUT)) u_watch (
    .clk(clk), .rst(rst), .load(accept), .run(busy_q), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      open_q    <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      rej_q     <= 1'b0;
      err_q     <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      shreg     <= '0;
      rx_q      <= '0;
      bitn      <= '0;
      rd_mode   <= 1'b0;
      nack_last <= 1'b0;
      ackn_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      if (busy_q && expired) begin
        state     <= S_IDLE;
        busy_q    <= 1'b0;
        open_q    <= 1'b0;
        err_q     <= 1'b1;
        scl_low_q <= 1'b0;
        sda_low_q <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: begin
            if (cmd_valid) begin
              case (cmd_op)
                OP_START: begin
                  err_q  <= 1'b0;
                  busy_q <= 1'b1;
                  if (open_q) begin
                    sda_low_q <= 1'b0;
                    state     <= S_ST_A;
                  end else begin
                    state <= S_ST_B;
                  end
                end
                OP_WRITE, OP_ADDR, OP_READ: begin
                  if (!open_q) begin
                    rej_q <= 1'b1;
                  end else begin
                    err_q     <= 1'b0;
                    busy_q    <= 1'b1;
                    rd_mode   <= (cmd_op == OP_READ);
                    nack_last <= cmd_flag;
                    bitn      <= '0;
                    state     <= S_B_L0;
                    if (cmd_op == OP_ADDR)      shreg <= {cmd_data[BYTE_W-2:0], cmd_flag};
                    else if (cmd_op == OP_READ) shreg <= '1;
                    else                        shreg <= cmd_data;
                  end
                end
                OP_STOP: begin
                  if (!open_q) begin
                    rej_q <= 1'b1;
                  end else begin
                    err_q  <= 1'b0;
                    busy_q <= 1'b1;
                    state  <= S_SP_A;
                  end
                end
                default: rej_q <= 1'b1;
              endcase
            end
          end
          // START / repeated START
          S_ST_A: if (tick) begin
            scl_low_q <= 1'b0;
            state     <= S_ST_B;
          end
          S_ST_B: if (tick && scl_s && sda_s) begin
            sda_low_q <= 1'b1;
            state     <= S_ST_C;
          end
          S_ST_C: if (tick) begin
            scl_low_q <= 1'b1;
            state     <= S_ST_D;
          end
          S_ST_D: if (tick) begin
            open_q <= 1'b1;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
          // one bit: low, set data, release clock, sample
          S_B_L0: if (tick) begin
            if (bitn == ACK_BIT) sda_low_q <= rd_mode ? !nack_last : 1'b0;
            else                 sda_low_q <= rd_mode ? 1'b0 : !shreg[BYTE_W-1];
            state <= S_B_L1;
          end
          S_B_L1: if (tick) begin
            scl_low_q <= 1'b0;
            state     <= S_B_H0;
          end
          S_B_H0: if (tick && scl_s) state <= S_B_H1;
          S_B_H1: if (tick) begin
            scl_low_q <= 1'b1;
            if (bitn == ACK_BIT) begin
              if (rd_mode) rx_q   <= shreg;
              else         ackn_q <= sda_s;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              bitn  <= bitn + 1'b1;
              state <= S_B_L0;
            end
          end
          // STOP
          S_SP_A: if (tick) begin
            sda_low_q <= 1'b1;
            state     <= S_SP_B;
          end
          S_SP_B: if (tick) begin
            scl_low_q <= 1'b0;
            state     <= S_SP_C;
          end
          S_SP_C: if (tick && scl_s) begin
            sda_low_q <= 1'b0;
            state     <= S_SP_D;
          end
          S_SP_D: if (tick && sda_s) begin
            open_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign rejected    = rej_q;
  assign timeout_err = err_q;
  assign bus_open    = open_q;
  assign rx_byte     = rx_q;
  assign ack_nack    = ackn_q;
  assign scl_pull    = scl_low_q;
  assign sda_pull    = sda_low_q;
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker #(
  parameter int TIMEOUT = 6000
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       rejected,
  input logic       timeout_err,
  input logic       bus_open,
  input logic       scl_in,
  input logic       sda_in,
  input logic       scl_pull,
  input logic       sda_pull
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_idle_stop_noop_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 3'd5 && !bus_open)
      |=> (rejected && !busy && !bus_open && !scl_pull && !sda_pull));

  assert_closed_byte_reject_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && !bus_open && (cmd_op == 3'd2 || cmd_op == 3'd3 || cmd_op == 3'd4))
      |=> (rejected && !busy));

  assert_wait_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    busy_run <= TIMEOUT + 1);

  assert_abort_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> (!busy && !bus_open && !scl_pull && !sda_pull));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (timeout_err && !(cmd_valid && !busy)) |=> timeout_err);

  assert_closed_released_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !bus_open) |-> (!scl_pull && !sda_pull));

  assert_stop_complete_R5: assert property (@(posedge clk) disable iff (rst)
    (done && $fell(bus_open)) |-> (scl_in && sda_in));

  assert_single_outcome_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, rejected}));
endmodule

bind i2c_bounded_master i2cb_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .rejected(rejected), .timeout_err(timeout_err),
  .bus_open(bus_open), .scl_in(scl_in), .sda_in(sda_in),
  .scl_pull(scl_pull), .sda_pull(sda_pull)
);

// File: tb/i2c_bounded_master_tb.sv
module i2c_bounded_master_tb;
  localparam int QD = 4;
  localparam int TO = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_flag = 1'b0;
  logic       busy, done, rejected, timeout_err, bus_open, ack_nack;
  logic [7:0] rx_byte;
  logic       scl_pull, sda_pull;
  logic       s_scl_low = 1'b0, s_sda_low = 1'b0;
  logic       scl_bus, sda_bus;

  assign scl_bus = !(scl_pull || s_scl_low);
  assign sda_bus = !(sda_pull || s_sda_low);

  i2c_bounded_master #(.QDIV(QD), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_flag(cmd_flag), .busy(busy), .done(done),
    .rejected(rejected), .timeout_err(timeout_err), .bus_open(bus_open),
    .rx_byte(rx_byte), .ack_nack(ack_nack), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull)
  );

  int checks = 0, fails = 0, cyc = 0, idle_viol = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural slave at 7-bit address 0x08 ----------------
  logic [7:0] mem [8];
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  bit   active = 0, addr_ph = 0, is_tx = 0, first_data = 0, mack = 0, tx_started = 0;
  bit   hang = 0;
  int   bitcnt = 0, stretch_n = 0, stretch_left = 0;
  int   s_starts = 0, s_stops = 0, m_acks = 0, m_nacks = 0;
  logic [7:0] rxb = 8'h00, txb = 8'h00, last_addr = 8'h00;
  logic [2:0] ptr = 3'd0;
  bit   rec_en = 0;
  int   rises[$];

  always @(posedge clk) begin
    cyc++;
    if (rec_en && !prev_scl && scl_bus) rises.push_back(cyc);
    if (hang) s_scl_low <= 1'b1;
    else if (stretch_left > 0) begin
      stretch_left--;
      if (stretch_left == 0) s_scl_low <= 1'b0;
    end else s_scl_low <= 1'b0;

    if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
      active = 1; addr_ph = 1; bitcnt = 0; is_tx = 0; tx_started = 0;
      s_sda_low <= 1'b0; s_starts++;
    end else if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
      active = 0; s_sda_low <= 1'b0; s_stops++;
    end else if (active) begin
      if (!prev_scl && scl_bus) begin
        if (bitcnt < 8) begin
          if (!is_tx) rxb = {rxb[6:0], sda_bus};
        end else if (bitcnt == 8 && tx_started) begin
          mack = !sda_bus;
          if (mack) m_acks++; else m_nacks++;
        end
        bitcnt++;
      end else if (prev_scl && !scl_bus) begin
        if (bitcnt == 8) begin
          if (!is_tx) begin
            if (addr_ph) begin
              last_addr = rxb;
              addr_ph = 0;
              if (rxb[7:1] == 7'h08) begin
                s_sda_low <= 1'b1; is_tx = rxb[0]; mack = 1; first_data = 1;
              end else begin
                active = 0; s_sda_low <= 1'b0;
              end
            end else begin
              s_sda_low <= 1'b1;
              if (first_data) begin ptr = rxb[2:0]; first_data = 0; end
              else begin mem[ptr] = rxb; ptr = ptr + 3'd1; end
            end
          end else s_sda_low <= 1'b0;
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          if (is_tx && mack) begin
            txb = mem[ptr]; ptr = ptr + 3'd1; tx_started = 1;
            s_sda_low <= !txb[7];
          end else s_sda_low <= 1'b0;
          if (stretch_n > 0) begin s_scl_low <= 1'b1; stretch_left = stretch_n; end
        end else if (is_tx && bitcnt >= 1 && bitcnt <= 7) begin
          s_sda_low <= !txb[7-bitcnt];
        end
      end
    end
    prev_scl = scl_bus;
    prev_sda = sda_bus;
  end

  // per-clock model: closed and idle means no line is pulled
  always @(negedge clk)
    if (!rst && !busy && !bus_open && (scl_pull || sda_pull)) idle_viol++;

  // ---------------- command driver ----------------
  task automatic do_cmd(input logic [2:0] op, input logic [7:0] d, input logic f,
                        output int res, output int dur);
    int t0;
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_flag = f; t0 = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    res = -1;
    while (res < 0) begin
      if (done) res = 0;
      else if (rejected) res = 1;
      else if (timeout_err && !busy) res = 2;
      else @(negedge clk);
    end
    dur = cyc - t0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=%0d expected=<150000", cyc);
    summary();
  end

  initial begin
    int res, dur, st0, sp0;
    for (int i = 0; i < 8; i++) mem[i] = 8'h40 + 8'(i);
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk(!busy && !bus_open && !timeout_err, "R3 reset idle flags", {busy, bus_open, timeout_err}, 0);
    chk(!scl_pull && !sda_pull, "R3 reset lines released", {scl_pull, sda_pull}, 0);

    // STOP while closed
    st0 = s_stops;
    do_cmd(3'd5, 8'h00, 1'b0, res, dur);
    chk(res == 1 && dur == 1, "R4 idle stop rejected", res * 256 + dur, 1 * 256 + 1);
    chk(!bus_open && !scl_pull && !sda_pull && s_stops == st0, "R4 idle stop no effect",
        {bus_open, scl_pull, sda_pull}, 0);
    do_cmd(3'd2, 8'h55, 1'b0, res, dur);
    chk(res == 1 && !bus_open, "R12 closed write rejected", res, 1);

    // write transaction: reg 2 <= A5
    st0 = s_starts;
    do_cmd(3'd1, 8'h00, 1'b0, res, dur);
    chk(res == 0 && bus_open && s_starts == st0 + 1, "R3 start opens bus", s_starts - st0, 1);
    rises.delete(); rec_en = 1;
    do_cmd(3'd3, 8'h08, 1'b0, res, dur);
    rec_en = 0;
    chk(last_addr == 8'h10, "R2 write address byte", last_addr, 8'h10);
    chk(res == 0 && ack_nack == 1'b0, "R11 address acked", ack_nack, 0);
    chk(rises.size() == 9, "R1 nine clocks per byte", rises.size(), 9);
    begin
      int bad = 0;
      for (int i = 1; i < rises.size(); i++) if (rises[i] - rises[i-1] != 4 * QD) bad++;
      chk(bad == 0, "R1 scl period", bad, 0);
    end
    chk(dur == 36 * QD + 1, "R1 byte duration", dur, 36 * QD + 1);
    do_cmd(3'd2, 8'h02, 1'b0, res, dur);
    do_cmd(3'd2, 8'hA5, 1'b0, res, dur);
    chk(res == 0 && ack_nack == 1'b0, "R11 data acked", ack_nack, 0);
    sp0 = s_stops;
    do_cmd(3'd5, 8'h00, 1'b0, res, dur);
    chk(res == 0 && !bus_open && s_stops == sp0 + 1, "R5 stop closes bus", s_stops - sp0, 1);
    chk(scl_bus && sda_bus, "R5 lines high after stop", {scl_bus, sda_bus}, 3);
    chk(mem[2] == 8'hA5, "R4 transaction after refused stop", mem[2], 8'hA5);

    // combined read of reg 2 and 3
    do_cmd(3'd1, 8'h00, 1'b0, res, dur);
    do_cmd(3'd3, 8'h08, 1'b0, res, dur);
    do_cmd(3'd2, 8'h02, 1'b0, res, dur);
    st0 = s_starts;
    do_cmd(3'd1, 8'h00, 1'b0, res, dur);
    chk(res == 0 && bus_open && s_starts == st0 + 1, "R3 repeated start", s_starts - st0, 1);
    do_cmd(3'd3, 8'h08, 1'b1, res, dur);
    chk(last_addr == 8'h11, "R2 read address byte", last_addr, 8'h11);
    st0 = m_acks;
    do_cmd(3'd4, 8'h00, 1'b0, res, dur);
    chk(rx_byte == 8'hA5, "R10 combined read first byte", rx_byte, 8'hA5);
    chk(m_acks == st0 + 1, "R9 ack on non-last read", m_acks - st0, 1);
    st0 = m_nacks;
    do_cmd(3'd4, 8'h00, 1'b1, res, dur);
    chk(rx_byte == 8'h43, "R10 combined read second byte", rx_byte, 8'h43);
    chk(m_nacks == st0 + 1, "R9 nack on last read", m_nacks - st0, 1);
    do_cmd(3'd5, 8'h00, 1'b0, res, dur);
    chk(res == 0 && !bus_open, "R5 stop after read", bus_open, 0);

    // absent device
    do_cmd(3'd1, 8'h00, 1'b0, res, dur);
    do_cmd(3'd3, 8'h33, 1'b0, res, dur);
    chk(res == 0 && ack_nack == 1'b1, "R11 absent address nack", ack_nack, 1);
    do_cmd(3'd5, 8'h00, 1'b0, res, dur);

    // clock stretching within budget
    stretch_n = 60;
    do_cmd(3'd1, 8'h00, 1'b0, res, dur);
    do_cmd(3'd3, 8'h08, 1'b0, res, dur);
    do_cmd(3'd2, 8'h04, 1'b0, res, dur);
    chk(res == 0 && !timeout_err && dur > 36 * QD + 40, "R8 stretched byte completes", dur, 36 * QD + 41);
    do_cmd(3'd2, 8'h3C, 1'b0, res, dur);
    stretch_n = 0;
    do_cmd(3'd5, 8'h00, 1'b0, res, dur);
    chk(mem[4] == 8'h3C && !timeout_err, "R8 stretched data delivered", mem[4], 8'h3C);

    // slave holds SCL forever
    do_cmd(3'd1, 8'h00, 1'b0, res, dur);
    do_cmd(3'd3, 8'h08, 1'b0, res, dur);
    hang = 1;
    do_cmd(3'd2, 8'h77, 1'b0, res, dur);
    chk(res == 2 && dur == TO + 2, "R6 timeout cycle", dur, TO + 2);
    chk(!busy && !bus_open && !scl_pull && !sda_pull, "R6 abort releases bus",
        {busy, bus_open, scl_pull, sda_pull}, 0);
    hang = 0;
    repeat (20) @(negedge clk);
    chk(timeout_err == 1'b1, "R7 error sticky while idle", timeout_err, 1);
    do_cmd(3'd5, 8'h00, 1'b0, res, dur);
    chk(res == 1 && timeout_err, "R7 rejected stop keeps error", timeout_err, 1);
    do_cmd(3'd1, 8'h00, 1'b0, res, dur);
    chk(res == 0 && !timeout_err, "R7 next command clears error", timeout_err, 0);
    do_cmd(3'd3, 8'h08, 1'b0, res, dur);
    chk(res == 0 && ack_nack == 1'b0, "R4 recovery address acked", ack_nack, 0);
    do_cmd(3'd5, 8'h00, 1'b0, res, dur);
    chk(res == 0 && !bus_open, "R5 recovery stop", bus_open, 0);

    chk(idle_viol == 0, "R3 closed idle never pulls", idle_viol, 0);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule